// File: doc/BRIEF.md
# Network controller command and interrupt register bank

This block is the host-facing register bank of a network controller. A host reaches it through a word-addressed bus with one write strobe and a combinational read port. Every register is 16 bits wide. The bank holds a command register, an interrupt status/mask pair that drives one level-sensitive interrupt line, transmit and receive control words, two configuration words that are writable only while the controller is held in software reset, an end-of-buffer threshold, a fixed revision word and a small group of error counters that store the complement of what the host writes.

Writing the command register starts actions in other engines. The bank turns the write into one-cycle request pulses for transmit, fetching a receive resource and loading the address filter. The engines report back with completion pulses and a general event vector, and these set bits in the interrupt status register. The host acknowledges interrupts by writing ones to the status bits it has handled.

Word map (the default `ADDR_W` is 4): 0 command, 1 interrupt status, 2 interrupt mask, 3 transmit control, 4 receive control, 5 configuration, 6 second configuration, 7 end-of-buffer count, 8 revision, 9 to 11 filter data ports, 12 to 14 inverted counters. Word 15 is unmapped. Unmapped words and the filter ports read 0 and ignore writes.

Top module: `nic_ctl_regs`

## Requirements
- R1: After reset the command word reads 0x0094, status and mask read 0, the end-of-buffer count reads 0x02F8, the revision word reads 0x0004 and the interrupt output is low.
- R2: The interrupt output is high exactly when the mask and status words share a set bit. It follows any change of either word by the next cycle.
- R3: A status write clears the bits that are written as 1 and are currently set, and leaves every other bit alone. Event-vector bits are ORed into status in the same cycle, and an event wins over a clear of the same bit.
- R4: A status write that clears the buffers-exhausted bit (0x0020) produces a one-cycle read-resource request. A write of that bit while it is already clear produces no request.
- R5: A mask write stores the written value with bit 15 forced to 0.
- R6: While the reset bit (0x0080) of the command word is set, a command write without that bit only clears the reset bit. It produces no request pulse and changes nothing else.
- R7: Any other command write ORs (value AND 0x03BF) into the command word. Bit 0x0002 pulses the transmit request, 0x0100 pulses the read-resource request and 0x0200 pulses the filter-load request, each for one cycle. Bit 0x0100 always reads back as 0.
- R8: Receiver disable (0x0004) clears receiver enable (0x0008), and enable clears disable. Timer stop (0x0010) clears timer start (0x0020), and start clears stop. When both bits of a pair are written together, both end up clear.
- R9: A command write with the reset bit sets 0x0080 and 0x0004 and clears 0x0200, 0x0100, 0x0002 and 0x0001.
- R10: A transmit-control write keeps only bits 15:12. A receive-control write keeps the value AND 0xFFE0.
- R11: While the reset bit is set, the configuration word takes the value AND 0xBFFF and the second configuration word takes the value AND 0xF017. While the reset bit is clear, writes to both are ignored.
- R12: Each inverted counter stores the bitwise complement of the written value. Writes to the revision word and to the filter data ports have no effect.
- R13: A transmit-done pulse clears command bit 0x0002 and sets status bit 0x0200. A filter-done pulse clears command bit 0x0200 and sets status bit 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Word address for reads and writes |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the addressed word (combinational) |
| txDoneIn | input | 1 | Transmit engine finished |
| filterDoneIn | input | 1 | Address filter load finished |
| eventIn | input | 16 | Event bits ORed into the status word |
| irqOut | output | 1 | Level interrupt |
| txReqOut | output | 1 | One-cycle transmit request |
| resReqOut | output | 1 | One-cycle read-resource request |
| filterReqOut | output | 1 | One-cycle filter-load request |

## Verification
The bench uses the default parameters: a 4-bit address, three inverted counters placed at words 12 to 14, and the default revision and threshold values. With these settings all 16 words of the map are reachable, including the filter ports that cannot be written and the unmapped last word, so random writes to any address exercise the write-protection and read-zero behaviour. The small map also means random command writes often hit the reset bit, which moves the bank in and out of the gated configuration window and the leave-reset special case many times in one run.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  // word addresses
  localparam int A_CMD    = 0;
  localparam int A_STATUS = 1;
  localparam int A_MASK   = 2;
  localparam int A_TXCTL  = 3;
  localparam int A_RXCTL  = 4;
  localparam int A_CFG    = 5;
  localparam int A_CFG2   = 6;
  localparam int A_EOB    = 7;
  localparam int A_REV    = 8;

  // command bits (positions are decoded by the attached engines)
  localparam logic [15:0] CMD_HALT   = 16'h0001;
  localparam logic [15:0] CMD_TX     = 16'h0002;
  localparam logic [15:0] CMD_RXDIS  = 16'h0004;
  localparam logic [15:0] CMD_RXEN   = 16'h0008;
  localparam logic [15:0] CMD_TSTOP  = 16'h0010;
  localparam logic [15:0] CMD_TSTART = 16'h0020;
  localparam logic [15:0] CMD_RST    = 16'h0080;
  localparam logic [15:0] CMD_RES    = 16'h0100;
  localparam logic [15:0] CMD_FILT   = 16'h0200;
  localparam logic [15:0] CMD_WMASK  = 16'h03BF;
  localparam logic [15:0] CMD_INIT   = 16'h0094;

  // status bits
  localparam logic [15:0] ST_RBE     = 16'h0020;
  localparam logic [15:0] ST_TXDONE  = 16'h0200;
  localparam logic [15:0] ST_LDDONE  = 16'h1000;

  // write masks
  localparam logic [15:0] MASK_IMR   = 16'h7FFF;
  localparam logic [15:0] MASK_TXC   = 16'hF000;
  localparam logic [15:0] MASK_RXC   = 16'hFFE0;
  localparam logic [15:0] MASK_CFG   = 16'hBFFF;
  localparam logic [15:0] MASK_CFG2  = 16'hF017;

  // strobes from control to datapath
  typedef struct packed {
    logic statusWr;
    logic maskWr;
    logic txCtlWr;
    logic rxCtlWr;
    logic cfgWr;
    logic cfg2Wr;
    logic eobWr;
    logic invWr;
    logic txGo;
    logic resGo;
    logic filtGo;
  } ctlStrobes_t;
endpackage

// File: rtl/nic_regs_ctrl.sv
module nic_regs_ctrl
  import nic_regs_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int INV_BASE = 12,
  parameter int N_INV    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [15:0]       busWrData,
  input  logic              txDoneIn,
  input  logic              filterDoneIn,
  output logic [15:0]       cmdQ,
  output ctlStrobes_t       strb
);
  localparam int INV_LAST = INV_BASE + N_INV - 1;

  logic        cmdHit;
  logic        leaveRst;
  logic        cmdApply;
  logic [15:0] cmdVal;
  logic [15:0] cmdD;
  logic        invHit;

  assign cmdHit   = busWrEn && (busAddr == ADDR_W'(A_CMD));
  assign leaveRst = cmdHit && ((cmdQ & CMD_RST) != '0) && ((busWrData & CMD_RST) == '0);
  assign cmdApply = cmdHit && !leaveRst;
  assign cmdVal   = busWrData & CMD_WMASK;

  always_comb begin
    cmdD = cmdQ;
    if (txDoneIn)     cmdD = cmdD & ~CMD_TX;
    if (filterDoneIn) cmdD = cmdD & ~CMD_FILT;
    if (leaveRst) begin
      cmdD = cmdD & ~CMD_RST;
    end else if (cmdApply) begin
      cmdD = cmdD | cmdVal;
      if ((cmdVal & CMD_RXDIS)  != '0) cmdD = cmdD & ~CMD_RXEN;
      if ((cmdVal & CMD_RXEN)   != '0) cmdD = cmdD & ~CMD_RXDIS;
      if ((cmdVal & CMD_TSTOP)  != '0) cmdD = cmdD & ~CMD_TSTART;
      if ((cmdVal & CMD_TSTART) != '0) cmdD = cmdD & ~CMD_TSTOP;
      if ((cmdVal & CMD_RST) != '0) begin
        cmdD = cmdD & ~(CMD_FILT | CMD_RES | CMD_TX | CMD_HALT);
        cmdD = cmdD | CMD_RST | CMD_RXDIS;
      end
      cmdD = cmdD & ~CMD_RES;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdQ <= CMD_INIT;
    else       cmdQ <= cmdD;
  end

  assign invHit = (int'(busAddr) >= INV_BASE) && (int'(busAddr) <= INV_LAST);

  always_comb begin
    strb          = '0;
    strb.statusWr = busWrEn && (busAddr == ADDR_W'(A_STATUS));
    strb.maskWr   = busWrEn && (busAddr == ADDR_W'(A_MASK));
    strb.txCtlWr  = busWrEn && (busAddr == ADDR_W'(A_TXCTL));
    strb.rxCtlWr  = busWrEn && (busAddr == ADDR_W'(A_RXCTL));
    strb.cfgWr    = busWrEn && (busAddr == ADDR_W'(A_CFG))  && ((cmdQ & CMD_RST) != '0);
    strb.cfg2Wr   = busWrEn && (busAddr == ADDR_W'(A_CFG2)) && ((cmdQ & CMD_RST) != '0);
    strb.eobWr    = busWrEn && (busAddr == ADDR_W'(A_EOB));
    strb.invWr    = busWrEn && invHit;
    strb.txGo     = cmdApply && ((cmdVal & CMD_TX)   != '0);
    strb.resGo    = cmdApply && ((cmdVal & CMD_RES)  != '0);
    strb.filtGo   = cmdApply && ((cmdVal & CMD_FILT) != '0);
  end
endmodule

// File: rtl/nic_regs_dp.sv
module nic_regs_dp
  import nic_regs_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          INV_BASE  = 12,
  parameter int          N_INV     = 3,
  parameter logic [15:0] REV_ID    = 16'h0004,
  parameter logic [15:0] EOB_RESET = 16'h02F8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWrData,
  input  logic [15:0]       cmdQ,
  input  logic [15:0]       eventIn,
  input  logic              txDoneIn,
  input  logic              filterDoneIn,
  output logic [15:0]       rdData,
  output logic [15:0]       statusQ,
  output logic [15:0]       maskQ,
  output logic              txReqOut,
  output logic              resReqOut,
  output logic              filterReqOut
);
  logic [15:0] txCtlQ, rxCtlQ, cfgQ, cfg2Q, eobQ;
  logic [15:0] invQ [N_INV];
  logic [15:0] clrBits;
  logic [15:0] statusD;
  logic        rbeCleared;

  assign clrBits    = strb.statusWr ? (busWrData & statusQ) : '0;
  assign rbeCleared = (clrBits & ST_RBE) != '0;

  always_comb begin
    statusD = (statusQ & ~clrBits) | eventIn;
    if (txDoneIn)     statusD = statusD | ST_TXDONE;
    if (filterDoneIn) statusD = statusD | ST_LDDONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ      <= '0;
      maskQ        <= '0;
      txCtlQ       <= '0;
      rxCtlQ       <= '0;
      cfgQ         <= '0;
      cfg2Q        <= '0;
      eobQ         <= EOB_RESET;
      txReqOut     <= 1'b0;
      resReqOut    <= 1'b0;
      filterReqOut <= 1'b0;
    end else begin
      statusQ      <= statusD;
      if (strb.maskWr)  maskQ  <= busWrData & MASK_IMR;
      if (strb.txCtlWr) txCtlQ <= busWrData & MASK_TXC;
      if (strb.rxCtlWr) rxCtlQ <= busWrData & MASK_RXC;
      if (strb.cfgWr)   cfgQ   <= busWrData & MASK_CFG;
      if (strb.cfg2Wr)  cfg2Q  <= busWrData & MASK_CFG2;
      if (strb.eobWr)   eobQ   <= busWrData;
      txReqOut     <= strb.txGo;
      resReqOut    <= strb.resGo | rbeCleared;
      filterReqOut <= strb.filtGo;
    end
  end

  for (genvar gi = 0; gi < N_INV; gi++) begin : g_inv
    always_ff @(posedge clk) begin
      if (!rstN)
        invQ[gi] <= '0;
      else if (strb.invWr && (busAddr == ADDR_W'(INV_BASE + gi)))
        invQ[gi] <= ~busWrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (int'(busAddr))
      A_CMD:    rdData = cmdQ;
      A_STATUS: rdData = statusQ;
      A_MASK:   rdData = maskQ;
      A_TXCTL:  rdData = txCtlQ;
      A_RXCTL:  rdData = rxCtlQ;
      A_CFG:    rdData = cfgQ;
      A_CFG2:   rdData = cfg2Q;
      A_EOB:    rdData = eobQ;
      A_REV:    rdData = REV_ID;
      default:  rdData = '0;
    endcase
    for (int i = 0; i < N_INV; i++)
      if (busAddr == ADDR_W'(INV_BASE + i)) rdData = invQ[i];
  end
endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
  import nic_regs_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          INV_BASE  = 12,
  parameter int          N_INV     = 3,
  parameter logic [15:0] REV_ID    = 16'h0004,
  parameter logic [15:0] EOB_RESET = 16'h02F8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  input  logic              txDoneIn,
  input  logic              filterDoneIn,
  input  logic [15:0]       eventIn,
  output logic              irqOut,
  output logic              txReqOut,
  output logic              resReqOut,
  output logic              filterReqOut
);
  ctlStrobes_t strb;
  logic [15:0] cmdQ;
  logic [15:0] statusQ;
  logic [15:0] maskQ;

  nic_regs_ctrl #(.ADDR_W(ADDR_W), .INV_BASE(INV_BASE), .N_INV(N_INV)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .txDoneIn(txDoneIn), .filterDoneIn(filterDoneIn),
    .cmdQ(cmdQ), .strb(strb)
  );

  nic_regs_dp #(.ADDR_W(ADDR_W), .INV_BASE(INV_BASE), .N_INV(N_INV),
                .REV_ID(REV_ID), .EOB_RESET(EOB_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWrData(busWrData), .cmdQ(cmdQ), .eventIn(eventIn),
    .txDoneIn(txDoneIn), .filterDoneIn(filterDoneIn), .rdData(busRdData),
    .statusQ(statusQ), .maskQ(maskQ), .txReqOut(txReqOut),
    .resReqOut(resReqOut), .filterReqOut(filterReqOut)
  );

  assign irqOut = (maskQ & statusQ) != '0;
endmodule

// File: rtl/nic_ctl_regs_chk.sv
module nic_ctl_regs_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [15:0]       busWrData,
  input logic [15:0]       eventIn,
  input logic [15:0]       cmdQ,
  input logic [15:0]       statusQ,
  input logic              irqOut,
  input logic              txReqOut,
  input logic              resReqOut,
  input logic              filterReqOut
);
  logic cmdWr, statusWr, maskWr;
  assign cmdWr    = busWrEn && (busAddr == ADDR_W'(0));
  assign statusWr = busWrEn && (busAddr == ADDR_W'(1));
  assign maskWr   = busWrEn && (busAddr == ADDR_W'(2));

  assert_mask_zero_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    maskWr && (busWrData[14:0] == 15'd0) |=> !irqOut);

  assert_event_sets_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn != 16'd0) |=> ((statusQ & $past(eventIn)) == $past(eventIn)));

  assert_rbe_fetch_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusWr && busWrData[5] && statusQ[5] |=> resReqOut);

  assert_leave_reset_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && cmdQ[7] && !busWrData[7] |=> !txReqOut && !resReqOut && !filterReqOut);

  assert_tx_pulse_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    txReqOut |-> $past(cmdWr && busWrData[1]));

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && busWrData[7] |=> cmdQ[7] && cmdQ[2] && !cmdQ[9] && !cmdQ[8] && !cmdQ[1] && !cmdQ[0]);
endmodule

bind nic_ctl_regs nic_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .eventIn(eventIn), .cmdQ(cmdQ), .statusQ(statusQ),
  .irqOut(irqOut), .txReqOut(txReqOut), .resReqOut(resReqOut),
  .filterReqOut(filterReqOut)
);

// File: tb/nic_ctl_regs_tb.sv
module nic_ctl_regs_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [15:0]       busWrData = '0;
  logic [15:0]       busRdData;
  logic              txDoneIn = 1'b0;
  logic              filterDoneIn = 1'b0;
  logic [15:0]       eventIn = '0;
  logic              irqOut, txReqOut, resReqOut, filterReqOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  // model state
  logic [15:0] mCmd, mStatus, mMask, mTx, mRx, mCfg, mCfg2, mEob;
  logic [15:0] mInv [3];
  logic eTx, eRes, eFilt;

  always #(CLK_P/2) clk = ~clk;

  nic_ctl_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .txDoneIn(txDoneIn),
    .filterDoneIn(filterDoneIn), .eventIn(eventIn), .irqOut(irqOut),
    .txReqOut(txReqOut), .resReqOut(resReqOut), .filterReqOut(filterReqOut)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mRead(int a);
    case (a)
      0: return mCmd;
      1: return mStatus;
      2: return mMask;
      3: return mTx;
      4: return mRx;
      5: return mCfg;
      6: return mCfg2;
      7: return mEob;
      8: return 16'h0004;
      12, 13, 14: return mInv[a-12];
      default: return 16'h0000;
    endcase
  endfunction

  function automatic void modelReset();
    mCmd = 16'h0094; mStatus = 0; mMask = 0; mTx = 0; mRx = 0;
    mCfg = 0; mCfg2 = 0; mEob = 16'h02F8;
    for (int i = 0; i < 3; i++) mInv[i] = 0;
  endfunction

  function automatic void modelStep(logic wr, int a, logic [15:0] d,
                                    logic [15:0] ev, logic txd, logic fd);
    logic [15:0] clr, c, v;
    eTx = 0; eRes = 0; eFilt = 0;
    clr = (wr && a == 1) ? (d & mStatus) : 16'h0;
    if (clr[5]) eRes = 1;
    c = mCmd;
    if (txd) c &= ~16'h0002;
    if (fd)  c &= ~16'h0200;
    if (wr && a == 0) begin
      if (mCmd[7] && !d[7]) c &= ~16'h0080;
      else begin
        v = d & 16'h03BF;
        c |= v;
        if (v[2]) c &= ~16'h0008;
        if (v[3]) c &= ~16'h0004;
        if (v[4]) c &= ~16'h0020;
        if (v[5]) c &= ~16'h0010;
        if (v[7]) begin c &= ~16'h0303; c |= 16'h0084; end
        c &= ~16'h0100;
        eTx = v[1]; eFilt = v[9]; if (v[8]) eRes = 1;
      end
    end
    if (wr) begin
      case (a)
        2: mMask = d & 16'h7FFF;
        3: mTx   = d & 16'hF000;
        4: mRx   = d & 16'hFFE0;
        5: if (mCmd[7]) mCfg  = d & 16'hBFFF;
        6: if (mCmd[7]) mCfg2 = d & 16'hF017;
        7: mEob = d;
        12, 13, 14: mInv[a-12] = ~d;
        default: ;
      endcase
    end
    mStatus = (mStatus & ~clr) | ev | (txd ? 16'h0200 : 16'h0) | (fd ? 16'h1000 : 16'h0);
    mCmd = c;
  endfunction

  // one clock of stimulus, then compare request pulses and interrupt
  task automatic step(logic wr, int a, logic [15:0] d, logic [15:0] ev,
                      logic txd, logic fd, string req);
    @(negedge clk);
    busWrEn = wr; busAddr = ADDR_W'(a); busWrData = d;
    eventIn = ev; txDoneIn = txd; filterDoneIn = fd;
    modelStep(wr, a, d, ev, txd, fd);
    @(negedge clk);
    busWrEn = 0; eventIn = 0; txDoneIn = 0; filterDoneIn = 0;
    check({req, " txReq"},  {15'd0, txReqOut},     {15'd0, eTx});
    check({req, " resReq"}, {15'd0, resReqOut},    {15'd0, eRes});
    check({req, " filtReq"},{15'd0, filterReqOut}, {15'd0, eFilt});
    check({req, " R2 irq"}, {15'd0, irqOut},       {15'd0, (mMask & mStatus) != 0});
  endtask

  task automatic wr(int a, logic [15:0] d, string req);
    step(1'b1, a, d, 16'h0, 1'b0, 1'b0, req);
  endtask

  task automatic rdChk(int a, string req);
    busAddr = ADDR_W'(a);
    #1;
    check(req, busRdData, mRead(a));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busAddr = 0; #1; check("R1 cmd", busRdData, 16'h0094);
    busAddr = 1; #1; check("R1 status", busRdData, 16'h0000);
    busAddr = 2; #1; check("R1 mask", busRdData, 16'h0000);
    busAddr = 7; #1; check("R1 eob", busRdData, 16'h02F8);
    busAddr = 8; #1; check("R1 rev", busRdData, 16'h0004);
    check("R1 irq", {15'd0, irqOut}, 16'h0);

    // R11 config writable in reset
    wr(5, 16'hFFFF, "R11 cfg"); rdChk(5, "R11 cfg value");
    check("R11 cfg literal", busRdData, 16'hBFFF);
    wr(6, 16'hFFFF, "R11 cfg2"); rdChk(6, "R11 cfg2 value");
    check("R11 cfg2 literal", busRdData, 16'hF017);

    // R6 leaving reset
    wr(0, 16'h0302, "R6 leave");
    rdChk(0, "R6 cmd");
    check("R6 cmd literal", busRdData, 16'h0014);

    // R11 locked outside reset
    wr(5, 16'h1234, "R11 locked"); rdChk(5, "R11 cfg unchanged");

    // R7 command actions
    wr(0, 16'h0302, "R7 go");
    rdChk(0, "R7 cmd");
    check("R7 cmd literal", busRdData, 16'h0216);

    // R13 completions
    step(0, 0, 0, 0, 1, 0, "R13 txdone");
    rdChk(0, "R13 cmd tx clear"); rdChk(1, "R13 status txdone");
    step(0, 0, 0, 0, 0, 1, "R13 filtdone");
    rdChk(0, "R13 cmd filt clear"); rdChk(1, "R13 status lddone");
    check("R13 status literal", busRdData, 16'h1200);

    // R5 / R2
    wr(2, 16'hFFFF, "R5 mask");
    rdChk(2, "R5 mask value");
    check("R5 mask literal", busRdData, 16'h7FFF);
    wr(1, 16'h1200, "R2 clear all");
    rdChk(1, "R3 status cleared");

    // R8 pairs
    wr(0, 16'h0008, "R8 rxen"); rdChk(0, "R8 rxen cmd");
    wr(0, 16'h0004, "R8 rxdis"); rdChk(0, "R8 rxdis cmd");
    wr(0, 16'h0020, "R8 tstart"); rdChk(0, "R8 tstart cmd");
    wr(0, 16'h0010, "R8 tstop"); rdChk(0, "R8 tstop cmd");
    wr(0, 16'h000C, "R8 both rx"); rdChk(0, "R8 both rx cmd");

    // R4 buffers exhausted
    step(0, 0, 0, 16'h0020, 0, 0, "R4 event");
    wr(1, 16'h0020, "R4 clear rbe"); rdChk(1, "R4 status");
    wr(1, 16'h0020, "R4 clear again no req");

    // R3 event beats clear
    step(0, 0, 0, 16'h0400, 0, 0, "R3 set");
    step(1, 1, 16'h0400, 16'h0400, 0, 0, "R3 collide");
    rdChk(1, "R3 event wins");
    wr(1, 16'hFFFF, "R3 clear"); rdChk(1, "R3 cleared");

    // R9 software reset
    wr(0, 16'h0282, "R9 reset"); rdChk(0, "R9 cmd");

    // R10
    wr(3, 16'hFFFF, "R10 tx"); rdChk(3, "R10 txctl");
    wr(4, 16'hFFFF, "R10 rx"); rdChk(4, "R10 rxctl");

    // R12
    for (int i = 12; i < 15; i++) begin
      wr(i, 16'h00FF, "R12 inv"); rdChk(i, "R12 inv value");
    end
    wr(8, 16'hFFFF, "R12 rev"); rdChk(8, "R12 rev fixed");
    wr(10, 16'hFFFF, "R12 filt"); rdChk(10, "R12 filter port");

    // random mix
    for (int n = 0; n < 800; n++) begin
      int a;
      logic [15:0] d, ev;
      logic w, t, f;
      a  = int'($urandom % 16);
      d  = 16'($urandom);
      w  = ($urandom % 4) != 0;
      ev = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0;
      t  = ($urandom % 8) == 0;
      f  = ($urandom % 8) == 0;
      step(w, a, d, ev, t, f, "R3 R7 random");
      rdChk(a, "R12 random readback");
      rdChk(int'($urandom % 16), "R10 random readback");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule